// File: doc/BRIEF.md
# Trap and Interrupt Next-PC Controller

This block holds the program counter of a 32-bit processor whose most significant PC bit doubles as the privilege flag: when it is 1 the processor runs in kernel mode, when it is 0 in user mode. Every cycle, before the next instruction is fetched, the block decides where that fetch comes from. It can continue in sequence, follow a jump, enter the illegal-opcode handler, enter the external-interrupt handler, or restart at the reset vector. Each handler entry point has the privilege bit set, so the first handler instruction already runs in kernel mode.

On a trap entry the block takes over the register-file write controls for that cycle. It forces a write of the sequential return address into the exception register and blocks any memory write. In ordinary cycles it passes the decoder's write controls through unchanged. External interrupts are masked while the privilege bit is set, so handler code cannot be interrupted. A jump issued from user mode can never raise the privilege bit. A jump issued from kernel mode may lower it, and that is how a handler returns to user code.

Top module: `trap_pc_ctrl`

## Requirements
- R1: While `rst` is 1, `pc_next` is 0x80000000, `pc_sel` is 5, `rf_we` and `mem_we` are 0, and after the clock edge `pc` reads 0x80000000.
- R2: With no event pending and no jump, `pc_next` equals `pc`+4 computed on bits 30:0 only, with bit 31 kept, so 0xFFFFFFFC steps to 0x80000000. `pc_sel` is 0.
- R3: A jump (`jmp_en`=1) taken while `pc[31]`=0 loads `jmp_target` with bit 31 forced to 0. `pc_sel` is 2.
- R4: A jump taken while `pc[31]`=1 loads `jmp_target` unchanged, including bit 31, which may clear kernel mode. `pc_sel` is 2.
- R5: When `illop`=1, `pc_next` is 0x80000004 and `pc_sel` is 3 in either mode. The block drives `wa_sel`=1 (the exception register), `wd_sel`=0 (return address), `rf_we`=1 and `mem_we`=0.
- R6: When `irq`=1 and `pc[31]`=0, `pc_next` is 0x80000008 and `pc_sel` is 4, with the same write controls as R5.
- R7: When `pc[31]`=1, `irq` has no effect: `pc_next` and `pc_sel` are exactly what they would be with `irq`=0.
- R8: Priority, highest first: reset, illegal opcode, interrupt, jump, sequential.
- R9: When `pc_sel` is 0 or 2, the outputs `wa_sel`, `wd_sel`, `rf_we` and `mem_we` equal `dec_wa_sel`, `dec_wd_sel`, `dec_rf_we` and `dec_mem_we`.
- R10: `pc_inc` always equals `pc`+4 with bit 31 kept. It is the value written into the exception register on a trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | External interrupt request |
| illop | input | 1 | Illegal opcode flagged by decode |
| jmp_en | input | 1 | Current instruction redirects the PC |
| jmp_target | input | 32 | Jump or branch target |
| dec_wa_sel | input | 1 | Decoder write-address select |
| dec_wd_sel | input | 2 | Decoder write-data select |
| dec_rf_we | input | 1 | Decoder register-file write enable |
| dec_mem_we | input | 1 | Decoder memory write enable |
| pc | output | 32 | Current program counter (bit 31 = kernel mode) |
| pc_next | output | 32 | Address of the next fetch |
| pc_inc | output | 32 | Sequential return address |
| pc_sel | output | 3 | Source code: 0 seq, 2 jump, 3 illegal, 4 interrupt, 5 reset |
| wa_sel | output | 1 | Write-address select, 1 = exception register |
| wd_sel | output | 2 | Write-data select, 0 = return address |
| rf_we | output | 1 | Register-file write enable |
| mem_we | output | 1 | Memory write enable |

## Verification
Several properties are checked on every cycle. Interrupts never select the PC source while the kernel bit is set. A user-mode jump never leaves the PC in kernel mode. Every trap entry forces the exception-register write and blocks memory writes. The illegal opcode always wins over an interrupt, and the cycle after any trap entry runs with the kernel bit set. The exact vector values, the bit-31 wrap of the sequential step, the decoder pass-through and the return to user mode through a kernel jump are shown only by the bench's directed scenarios, which walk the PC between modes.

// File: rtl/trap_pc_pkg.sv
package trap_pc_pkg;

    typedef enum logic [2:0] {
        PCS_SEQ   = 3'd0,
        PCS_JUMP  = 3'd2,
        PCS_ILLOP = 3'd3,
        PCS_IRQ   = 3'd4,
        PCS_RESET = 3'd5
    } pcsel_e;

    typedef struct packed {
        logic       wa_sel;
        logic [1:0] wd_sel;
        logic       rf_we;
        logic       mem_we;
    } wctl_t;

    localparam logic       WA_XP     = 1'b1;
    localparam logic [1:0] WD_RETURN = 2'd0;

    function automatic logic is_trap(input pcsel_e s);
        return (s == PCS_ILLOP) || (s == PCS_IRQ);
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   irq,
    input  logic   illop,
    input  logic   jmp_en,
    input  logic   kmode,
    output pcsel_e sel
);
    logic irq_live;

    assign irq_live = irq && !kmode;

    always_comb begin
        if (rst)           sel = PCS_RESET;
        else if (illop)    sel = PCS_ILLOP;
        else if (irq_live) sel = PCS_IRQ;
        else if (jmp_en)   sel = PCS_JUMP;
        else               sel = PCS_SEQ;
    end

    AST_KERNEL_MASKS_IRQ: assert property (@(posedge clk) disable iff (rst)
        kmode |-> sel != PCS_IRQ);                            // R7
    AST_ILLOP_OUTRANKS: assert property (@(posedge clk) disable iff (rst)
        illop |-> sel == PCS_ILLOP);                          // R8
endmodule

// File: rtl/pc_steer.sv
module pc_steer
    import trap_pc_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] jmp_target,
    input  pcsel_e          sel,
    output logic [PC_W-1:0] pc_inc,
    output logic [PC_W-1:0] pc_next
);
    localparam int              MB        = PC_W - 1;
    localparam logic [PC_W-1:0] KBIT      = {1'b1, {(PC_W-1){1'b0}}};
    localparam logic [PC_W-1:0] VEC_RESET = KBIT;
    localparam logic [PC_W-1:0] VEC_ILLOP = KBIT | PC_W'(STEP);
    localparam logic [PC_W-1:0] VEC_IRQ   = KBIT | PC_W'(2 * STEP);

    logic [MB-1:0]   low_inc;
    logic [PC_W-1:0] jmp_eff;

    assign low_inc = pc[MB-1:0] + (MB)'(STEP);
    assign pc_inc  = {pc[MB], low_inc};
    assign jmp_eff = {jmp_target[MB] & pc[MB], jmp_target[MB-1:0]};

    always_comb begin
        unique case (sel)
            PCS_RESET: pc_next = VEC_RESET;
            PCS_ILLOP: pc_next = VEC_ILLOP;
            PCS_IRQ:   pc_next = VEC_IRQ;
            PCS_JUMP:  pc_next = jmp_eff;
            default:   pc_next = pc_inc;
        endcase
    end
endmodule

// File: rtl/wctl_override.sv
module wctl_override
    import trap_pc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  pcsel_e sel,
    input  wctl_t  dec,
    output wctl_t  ctl
);
    always_comb begin
        ctl = dec;
        if (sel == PCS_RESET) begin
            ctl.rf_we  = 1'b0;
            ctl.mem_we = 1'b0;
        end else if (is_trap(sel)) begin
            ctl.wa_sel = WA_XP;
            ctl.wd_sel = WD_RETURN;
            ctl.rf_we  = 1'b1;
            ctl.mem_we = 1'b0;
        end
    end

    AST_TRAP_SAVES_RETURN: assert property (@(posedge clk) disable iff (rst)
        (sel == PCS_ILLOP || sel == PCS_IRQ) |->
            (ctl.rf_we && ctl.wa_sel && ctl.wd_sel == 2'd0 && !ctl.mem_we)); // R5
endmodule

// File: rtl/trap_pc_ctrl.sv
module trap_pc_ctrl
    import trap_pc_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq,
    input  logic            illop,
    input  logic            jmp_en,
    input  logic [PC_W-1:0] jmp_target,
    input  logic            dec_wa_sel,
    input  logic [1:0]      dec_wd_sel,
    input  logic            dec_rf_we,
    input  logic            dec_mem_we,
    output logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_next,
    output logic [PC_W-1:0] pc_inc,
    output logic [2:0]      pc_sel,
    output logic            wa_sel,
    output logic [1:0]      wd_sel,
    output logic            rf_we,
    output logic            mem_we
);
    localparam int MB = PC_W - 1;

    pcsel_e sel;
    wctl_t  dec_ctl;
    wctl_t  out_ctl;
    logic [PC_W-1:0] pc_q;

    trap_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .irq    (irq),
        .illop  (illop),
        .jmp_en (jmp_en),
        .kmode  (pc_q[MB]),
        .sel    (sel)
    );

    pc_steer #(.PC_W(PC_W), .STEP(STEP)) u_steer (
        .pc         (pc_q),
        .jmp_target (jmp_target),
        .sel        (sel),
        .pc_inc     (pc_inc),
        .pc_next    (pc_next)
    );

    assign dec_ctl = '{wa_sel: dec_wa_sel, wd_sel: dec_wd_sel,
                       rf_we: dec_rf_we, mem_we: dec_mem_we};

    wctl_override u_wctl (
        .clk (clk),
        .rst (rst),
        .sel (sel),
        .dec (dec_ctl),
        .ctl (out_ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= {1'b1, {(PC_W-1){1'b0}}};
        else     pc_q <= pc_next;
    end

    assign pc     = pc_q;
    assign pc_sel = sel;
    assign wa_sel = out_ctl.wa_sel;
    assign wd_sel = out_ctl.wd_sel;
    assign rf_we  = out_ctl.rf_we;
    assign mem_we = out_ctl.mem_we;

    AST_USER_JUMP_STAYS_USER: assert property (@(posedge clk) disable iff (rst)
        (!pc[MB] && pc_sel == 3'd2) |=> !pc[MB]);             // R3
    AST_TRAP_ENTERS_KERNEL: assert property (@(posedge clk) disable iff (rst)
        (pc_sel == 3'd3 || pc_sel == 3'd4) |=> pc[MB]);       // R6
endmodule

// File: tb/trap_pc_ctrl_test.sv
module trap_pc_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0, illop = 1'b0, jmp_en = 1'b0;
    logic [31:0] jmp_target = '0;
    logic        dec_wa_sel = 1'b0;
    logic [1:0]  dec_wd_sel = 2'd1;
    logic        dec_rf_we = 1'b0, dec_mem_we = 1'b0;
    logic [31:0] pc, pc_next, pc_inc;
    logic [2:0]  pc_sel;
    logic        wa_sel, rf_we, mem_we;
    logic [1:0]  wd_sel;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    trap_pc_ctrl uut (
        .clk(clk), .rst(rst), .irq(irq), .illop(illop), .jmp_en(jmp_en),
        .jmp_target(jmp_target), .dec_wa_sel(dec_wa_sel), .dec_wd_sel(dec_wd_sel),
        .dec_rf_we(dec_rf_we), .dec_mem_we(dec_mem_we), .pc(pc), .pc_next(pc_next),
        .pc_inc(pc_inc), .pc_sel(pc_sel), .wa_sel(wa_sel), .wd_sel(wd_sel),
        .rf_we(rf_we), .mem_we(mem_we)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, settle, leave comb outputs for checking
    task automatic drive(input logic i, input logic il, input logic j, input logic [31:0] t);
        @(negedge clk);
        irq = i; illop = il; jmp_en = j; jmp_target = t;
        #1;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_trap_ctl(input string req);
        chk(req, {31'd0, wa_sel}, 32'd1);
        chk(req, {30'd0, wd_sel}, 32'd0);
        chk(req, {31'd0, rf_we}, 32'd1);
        chk(req, {31'd0, mem_we}, 32'd0);
    endtask

    task automatic t_reset();
        rst = 1'b1; dec_rf_we = 1'b1; dec_mem_we = 1'b1;
        drive(1'b0, 1'b1, 1'b0, 32'h0);
        chk("R1 next", pc_next, 32'h80000000);
        chk("R1/R8 sel", {29'd0, pc_sel}, 32'd5);
        chk("R1 rf_we", {31'd0, rf_we}, 32'd0);
        chk("R1 mem_we", {31'd0, mem_we}, 32'd0);
        tick();
        chk("R1 pc", pc, 32'h80000000);
        @(negedge clk); rst = 1'b0; illop = 1'b0; dec_rf_we = 1'b0; dec_mem_we = 1'b0;
    endtask

    task automatic t_kernel_return();
        drive(1'b0, 1'b0, 1'b1, 32'h00000100);
        chk("R4 sel", {29'd0, pc_sel}, 32'd2);
        chk("R4 next", pc_next, 32'h00000100);
        tick();
        chk("R4 pc user", pc, 32'h00000100);
    endtask

    task automatic t_seq_passthru();
        dec_wa_sel = 1'b0; dec_wd_sel = 2'd2; dec_rf_we = 1'b1; dec_mem_we = 1'b1;
        drive(1'b0, 1'b0, 1'b0, 32'h0);
        chk("R2 next", pc_next, 32'h00000104);
        chk("R2 sel", {29'd0, pc_sel}, 32'd0);
        chk("R9 wa", {31'd0, wa_sel}, 32'd0);
        chk("R9 wd", {30'd0, wd_sel}, 32'd2);
        chk("R9 rf_we", {31'd0, rf_we}, 32'd1);
        chk("R9 mem_we", {31'd0, mem_we}, 32'd1);
        chk("R10 inc", pc_inc, 32'h00000104);
        tick();
        chk("R2 pc", pc, 32'h00000104);
    endtask

    task automatic t_irq_user();
        drive(1'b1, 1'b0, 1'b1, 32'h00000400);
        chk("R6/R8 sel", {29'd0, pc_sel}, 32'd4);
        chk("R6 next", pc_next, 32'h80000008);
        chk("R10 inc", pc_inc, 32'h00000108);
        chk_trap_ctl("R6 ctl");
        tick();
        chk("R6 pc", pc, 32'h80000008);
    endtask

    task automatic t_irq_masked();
        drive(1'b1, 1'b0, 1'b0, 32'h0);
        chk("R7 sel", {29'd0, pc_sel}, 32'd0);
        chk("R7 next", pc_next, 32'h8000000C);
        chk("R7 mem_we", {31'd0, mem_we}, 32'd1);
        tick();
        chk("R7 pc", pc, 32'h8000000C);
    endtask

    task automatic t_user_jump_high();
        drive(1'b1, 1'b0, 1'b1, 32'h00000200);   // kernel return, irq masked
        chk("R7/R4 sel", {29'd0, pc_sel}, 32'd2);
        tick();
        drive(1'b0, 1'b0, 1'b1, 32'h80001000);
        chk("R3 next", pc_next, 32'h00001000);
        tick();
        chk("R3 pc", pc, 32'h00001000);
    endtask

    task automatic t_illop_priority();
        dec_mem_we = 1'b1; dec_rf_we = 1'b0; dec_wd_sel = 2'd3;
        drive(1'b1, 1'b1, 1'b1, 32'h00000000);
        chk("R8 sel", {29'd0, pc_sel}, 32'd3);
        chk("R5 next", pc_next, 32'h80000004);
        chk("R10 inc", pc_inc, 32'h00001004);
        chk_trap_ctl("R5 ctl");
        tick();
        chk("R5 pc", pc, 32'h80000004);
        drive(1'b0, 1'b1, 1'b0, 32'h0);           // illegal opcode in kernel
        chk("R5 kernel sel", {29'd0, pc_sel}, 32'd3);
        chk("R10 kernel inc", pc_inc, 32'h80000008);
    endtask

    task automatic t_wrap();
        drive(1'b0, 1'b0, 1'b1, 32'hFFFFFFFC);
        tick();
        chk("R4 pc", pc, 32'hFFFFFFFC);
        drive(1'b0, 1'b0, 1'b0, 32'h0);
        chk("R2 wrap", pc_next, 32'h80000000);
        chk("R10 wrap", pc_inc, 32'h80000000);
        tick();
    endtask

    initial begin
        t_reset();
        t_kernel_return();
        t_seq_passthru();
        t_irq_user();
        t_irq_masked();
        t_user_jump_high();
        t_illop_priority();
        t_wrap();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule